// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter

This block turns a two-phase incremental encoder signal into a position count that can span 32 bits. A lower 16-bit channel decodes the two phase inputs and steps up or down on every edge of either input. An upper 16-bit channel either counts every clock or, when its source field selects the cascade source, steps up each time the lower channel wraps from all-ones to zero and steps down each time it wraps from zero to all-ones. Together the two channels form one signed-agnostic 32-bit position.

Software sets the upper channel's source field and the per-channel run bits through a small word-wide register port, and may read or preset either count at any time. The phase inputs are asynchronous to the block clock and pass through a two-stage synchronizer before their edges are decoded. The lower channel's wrap events also appear as single-cycle output pulses.

Top module: `cascade_quad_counter`

## Requirements
- R1: After reset the control register, the lower count, the upper count and both wrap pulses are all zero.
- R2: Register address 0 is control (bits 3:0 upper source field, bit 4 lower run bit, bit 5 upper run bit, bits 15:6 read zero), address 1 is the lower count and address 2 is the upper count; each reads back what was last written, and address 3 reads zero.
- R3: With its run bit set, the lower count steps by one on every edge of either phase input: up when the phase pair (A,B) moves through 00, 10, 11, 01 in that order (A leads) and down in the reverse order.
- R4: A sampled change of both phase inputs in the same cycle leaves the lower count unchanged.
- R5: The lower count wraps modulo 2^16; a step up from 16'hFFFF raises the up-wrap output and a step down from 16'h0000 raises the down-wrap output, each for exactly one cycle per wrap.
- R6: With source field 4'b1111 and both run bits set, the upper count rises by one on the same clock edge at which the lower count wraps from 16'hFFFF to 16'h0000.
- R7: With source field 4'b1111 and both run bits set, the upper count falls by one on the same clock edge at which the lower count wraps from 16'h0000 to 16'hFFFF.
- R8: The upper count wraps modulo 2^16 in both directions.
- R9: A channel whose run bit is clear keeps its count, while writes to that count still take effect.
- R10: With a source field other than 4'b1111 and its run bit set, the upper count rises by one on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, combinational from addr |
| lo_wrap_up | output | 1 | Lower count wraps from all-ones to zero this cycle |
| lo_wrap_dn | output | 1 | Lower count wraps from zero to all-ones this cycle |

## Verification
The bench walks the phase pair forward and backward edge by edge through a lower-count preset just below a wrap, so each step checks direction decoding, the lower wrap and the cascade into the upper count, with the upper count preset at all-ones or zero to expose its own wrap in both directions. Steps in which both phases flip together separate a valid edge from an invalid one. The same step sequences are repeated with one run bit cleared at a time, which tells apart a stopped lower channel, a stopped upper channel, and the clock-counting source against the cascade source.

// File: rtl/qc_pkg.sv
package qc_pkg;

    localparam int CNT_W  = 16;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 2;

    localparam logic [SEL_W-1:0]  SEL_CASCADE = '1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd2;

    typedef struct packed {
        logic             run_hi;
        logic             run_lo;
        logic [SEL_W-1:0] hi_src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    // Position of the phase pair along the forward sequence 00,10,11,01.
    function automatic logic [1:0] phase_pos(input logic a, input logic b);
        return {b, a ^ b};
    endfunction

    // One forward position is a step up, one backward a step down,
    // two apart means both inputs moved and is discarded.
    function automatic step_t phase_step(input logic [1:0] prev_pos,
                                         input logic [1:0] cur_pos);
        logic [1:0] diff;
        step_t      s;
        diff = cur_pos - prev_pos;
        s.up = (diff == 2'd1);
        s.dn = (diff == 2'd3);
        return s;
    endfunction

endpackage

// File: rtl/qc_phase_decoder.sv
module qc_phase_decoder
    import qc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  phase_a,
    input  logic  phase_b,
    output step_t step
);

    logic [SYNC_STAGES-1:0] sync_a;
    logic [SYNC_STAGES-1:0] sync_b;
    logic [1:0]             prev_pos;
    logic [1:0]             cur_pos;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_a <= '0;
                    sync_b <= '0;
                end else begin
                    sync_a <= phase_a;
                    sync_b <= phase_b;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_a <= '0;
                    sync_b <= '0;
                end else begin
                    sync_a <= {sync_a[SYNC_STAGES-2:0], phase_a};
                    sync_b <= {sync_b[SYNC_STAGES-2:0], phase_b};
                end
            end
        end
    endgenerate

    assign cur_pos = phase_pos(sync_a[SYNC_STAGES-1], sync_b[SYNC_STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) prev_pos <= '0;
        else     prev_pos <= cur_pos;
    end

    assign step = phase_step(prev_pos, cur_pos);

    // R3: a decoded step is never both directions at once
    p_one_dir_r3: assert property (@(posedge clk) disable iff (rst)
        !(step.up && step.dn));

    // R4: a double flip of the synchronized pair yields no step
    p_double_flip_r4: assert property (@(posedge clk) disable iff (rst)
        ((prev_pos ^ cur_pos) == 2'b10) |-> (!step.up && !step.dn));

endmodule

// File: rtl/qc_lower_counter.sv
module qc_lower_counter
    import qc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  step_t            step,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_up,
    output logic             wrap_dn
);

    logic active;

    assign active  = run && !wr;
    assign wrap_up = active && step.up && (cnt == '1);
    assign wrap_dn = active && step.dn && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (wr)                cnt <= wdata;
        else if (run && step.up)    cnt <= cnt + 1'b1;
        else if (run && step.dn)    cnt <= cnt - 1'b1;
    end

    // R5: an up-wrap lands on zero
    p_wrap_up_zero_r5: assert property (@(posedge clk) disable iff (rst)
        wrap_up |=> (cnt == '0));

    // R5: a down-wrap lands on all-ones
    p_wrap_dn_ones_r5: assert property (@(posedge clk) disable iff (rst)
        wrap_dn |=> (cnt == '1));

    // R9: a stopped channel with no write holds its count
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr) |=> $stable(cnt));

endmodule

// File: rtl/qc_upper_counter.sv
module qc_upper_counter
    import qc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] src,
    input  logic             ev_up,
    input  logic             ev_dn,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);

    logic cascade;
    logic inc;
    logic dec;

    assign cascade = (src == SEL_CASCADE);
    assign inc     = cascade ? ev_up : 1'b1;
    assign dec     = cascade && ev_dn;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (wr)          cnt <= wdata;
        else if (run && inc)  cnt <= cnt + 1'b1;
        else if (run && dec)  cnt <= cnt - 1'b1;
    end

    // R6: lower up-wrap advances the upper count on the same edge
    p_cascade_up_r6: assert property (@(posedge clk) disable iff (rst)
        (cascade && run && ev_up && !wr) |=> (cnt == $past(cnt) + 1'b1));

    // R7: lower down-wrap retreats the upper count on the same edge
    p_cascade_dn_r7: assert property (@(posedge clk) disable iff (rst)
        (cascade && run && ev_dn && !wr) |=> (cnt == $past(cnt) - 1'b1));

    // R9: a stopped upper channel with no write holds its count
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr) |=> $stable(cnt));

endmodule

// File: rtl/cascade_quad_counter.sv
module cascade_quad_counter
    import qc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              lo_wrap_up,
    output logic              lo_wrap_dn
);

    ctrl_t            ctrl;
    step_t            step;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;
    logic             wr_ctrl;
    logic             wr_lo;
    logic             wr_hi;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_lo   = wr_en && (addr == ADDR_LOW);
    assign wr_hi   = wr_en && (addr == ADDR_HIGH);

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    qc_phase_decoder #(.SYNC_STAGES(2)) decoder_i (
        .clk     (clk),
        .rst     (rst),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .step    (step)
    );

    qc_lower_counter lower_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run_lo),
        .step    (step),
        .wr      (wr_lo),
        .wdata   (wr_data),
        .cnt     (lo_cnt),
        .wrap_up (lo_wrap_up),
        .wrap_dn (lo_wrap_dn)
    );

    qc_upper_counter upper_i (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run_hi),
        .src   (ctrl.hi_src),
        .ev_up (lo_wrap_up),
        .ev_dn (lo_wrap_dn),
        .wr    (wr_hi),
        .wdata (wr_data),
        .cnt   (hi_cnt)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
            ADDR_LOW:  rd_data = lo_cnt;
            ADDR_HIGH: rd_data = hi_cnt;
            default:   rd_data = '0;
        endcase
    end

    // R5: the two wrap pulses never coincide
    p_wrap_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(lo_wrap_up && lo_wrap_dn));

    // R5: wrap pulses only occur while the lower channel runs
    p_wrap_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
        (lo_wrap_up || lo_wrap_dn) |-> ctrl.run_lo);

endmodule

// File: tb/cascade_quad_counter_tb.sv
module cascade_quad_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        lo_wrap_up;
    logic        lo_wrap_dn;

    int checks = 0;
    int errors = 0;
    int pos = 0;

    logic [15:0] m_lo = 16'h0;
    logic [15:0] m_hi = 16'h0;
    logic [5:0]  m_ctrl = 6'h0;
    int exp_up = 0, exp_dn = 0;
    int seen_up = 0, seen_dn = 0;
    int run_up = 0, run_dn = 0, max_run = 0;
    logic count_pulses = 1'b0;

    always #10 clk = ~clk;

    cascade_quad_counter dut_i (
        .clk (clk), .rst (rst), .phase_a (phase_a), .phase_b (phase_b),
        .wr_en (wr_en), .addr (addr), .wr_data (wr_data), .rd_data (rd_data),
        .lo_wrap_up (lo_wrap_up), .lo_wrap_dn (lo_wrap_dn)
    );

    always @(negedge clk) begin
        if (count_pulses) begin
            if (lo_wrap_up) begin seen_up++; run_up++; end else run_up = 0;
            if (lo_wrap_dn) begin seen_dn++; run_dn++; end else run_dn = 0;
            if (run_up > max_run) max_run = run_up;
            if (run_dn > max_run) max_run = run_dn;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) m_ctrl = d[5:0];
        if (a == 2'd1) m_lo = d;
        if (a == 2'd2) m_hi = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_counts(input string req);
        logic [15:0] v;
        rd(2'd1, v); chk({req, " lower"}, v, m_lo);
        rd(2'd2, v); chk({req, " upper"}, v, m_hi);
    endtask

    // dir: +1 forward, -1 backward, 2 both phases flip together
    task automatic qstep(input int dir);
        logic cas;
        pos = (pos + dir) & 3;
        @(negedge clk);
        phase_a = (pos == 1) || (pos == 2);
        phase_b = (pos >= 2);
        repeat (4) @(negedge clk);
        cas = (m_ctrl[3:0] == 4'hF) && m_ctrl[5];
        if (m_ctrl[4] && (dir == 1 || dir == -1)) begin
            if (dir == 1) begin
                if (m_lo == 16'hFFFF) begin exp_up++; if (cas) m_hi = m_hi + 16'h1; end
                m_lo = m_lo + 16'h1;
            end else begin
                if (m_lo == 16'h0000) begin exp_dn++; if (cas) m_hi = m_hi - 16'h1; end
                m_lo = m_lo - 16'h1;
            end
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, t0, t1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
        check_counts("R1");
        chk("R1 wrap_up", {15'h0, lo_wrap_up}, 16'h0);
        chk("R1 wrap_dn", {15'h0, lo_wrap_dn}, 16'h0);

        // R2 register map and readback
        wr(2'd0, 16'hFFEA); rd(2'd0, v); chk("R2 ctrl readback", v, 16'h002A);
        wr(2'd1, 16'hA5C3); rd(2'd1, v); chk("R2 lower readback", v, 16'hA5C3);
        wr(2'd2, 16'h1234); rd(2'd2, v); chk("R2 upper readback", v, 16'h1234);
        rd(2'd3, v); chk("R2 reserved address", v, 16'h0);

        count_pulses = 1'b1;
        // R3 R6 R8: forward sweep across an up-wrap, upper at all-ones
        wr(2'd0, 16'h003F);
        wr(2'd1, 16'hFFFA);
        wr(2'd2, 16'hFFFF);
        for (int i = 0; i < 12; i++) begin qstep(1); check_counts("R3 R6 R8 forward"); end
        // R3 R7 R8: backward sweep back across the wrap
        for (int i = 0; i < 12; i++) begin qstep(-1); check_counts("R3 R7 R8 backward"); end
        // R7 R8: upper at zero steps down to all-ones
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0002);
        for (int i = 0; i < 5; i++) begin qstep(-1); check_counts("R7 R8 down-wrap"); end
        rd(2'd2, v); chk("R8 upper wrapped", v, 16'hFFFF);

        // R4 simultaneous flips ignored
        for (int i = 0; i < 4; i++) begin qstep(2); check_counts("R4 double flip"); end
        qstep(1); check_counts("R4 after double flip");

        // R9 lower stopped: steps ignored, writes accepted
        wr(2'd0, 16'h002F);
        for (int i = 0; i < 4; i++) begin qstep(1); check_counts("R9 lower stopped"); end
        wr(2'd1, 16'hFFFE); check_counts("R9 write while stopped");
        // R9 upper stopped: lower wraps, upper holds
        wr(2'd0, 16'h001F);
        for (int i = 0; i < 4; i++) begin qstep(1); check_counts("R9 upper stopped"); end
        for (int i = 0; i < 4; i++) begin qstep(-1); check_counts("R9 upper stopped down"); end
        wr(2'd2, 16'h4444); check_counts("R9 upper write while stopped");

        // R5 wrap pulse counts and width
        chk("R5 up-wrap pulses", seen_up[15:0], exp_up[15:0]);
        chk("R5 down-wrap pulses", seen_dn[15:0], exp_dn[15:0]);
        chk("R5 pulse width", max_run[15:0], 16'h1);

        // R10 clock source counts every cycle
        wr(2'd0, 16'h0020);
        rd(2'd2, t0);
        repeat (10) @(negedge clk);
        rd(2'd2, t1);
        chk("R10 clock count", t1 - t0, 16'd10);
        wr(2'd0, 16'h0000);
        rd(2'd2, t0);
        repeat (5) @(negedge clk);
        rd(2'd2, t1);
        chk("R10 stopped", t1 - t0, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule